// File: doc/BRIEF.md
# Path Eviction Scheduler

This block performs the write-back half of a tree-shaped oblivious memory. Buckets form a binary tree of `L+1` levels. Level 0 is the root and level `L` holds the leaves. Each logical block carries an `L`-bit leaf label, and that label picks out one root-to-leaf path. For every access, the host names the leaf of the path it fetched and then streams in all `(L+1)*Z` slots it read along that path. Real blocks are kept in an internal stash. Dummy blocks, marked by the all-ones tag, are dropped.

Only every `PERIOD`-th access (by default every fifth) triggers a write-back. On that access the block walks the stash once, in index order. It drops each real entry straight into a per-level slot buffer, at the deepest level that the entry's own path shares with the current path and that still has a free slot. No sorting step is involved. The slot buffer is then streamed out over a valid/ready channel, root bucket first and slots in ascending order. The write-back always has the full path length, and empty slots are filled with dummy blocks.

When the scheme is switched off, the input stream is wired straight to the output stream and no path is expanded.

Top module: `path_evict_sched`

## Requirements
- R1: After reset, `out_valid`=0, `in_ready`=0 and `stash_err`=0. With `obl_en`=1, `acc_ready`=1 and the stash is empty.
- R2: An accepted access raises `in_ready` for exactly `(L+1)*Z` input beats (20 by default) and lowers it afterwards. `in_ready` stays low during placement and write-back.
- R3: The shared depth of two leaf labels is `L` when they are equal. Otherwise it is `L-1-p`, where `p` is the bit position of the highest set bit of their XOR (leaf bit `L-1` picks the branch below the root). Stash entries are visited in ascending index order. Each valid entry goes into the deepest level at or above its shared depth that holds fewer than `Z` blocks, in the next free slot of that level.
- R4: `stash_err` is sticky until reset. It is set when a real input block finds all `N` stash entries occupied (the block is dropped), or when an entry finds no free slot at any level from 0 to its shared depth. Such an entry stays in the stash.
- R5: Counting only accesses accepted while `obl_en`=1, the 5th, 10th, 15th… access produces a write-back. All other accesses produce no output beat, and their real blocks stay in the stash.
- R6: A write-back is exactly `(L+1)*Z` beats. Beat `k` carries the slot `k mod Z` of level `k div Z`. An empty slot is sent as tag 8'hFF with leaf 0 and data 0.
- R7: While `out_valid`=1 and `out_ready`=0 during a write-back, the output fields hold their values into the next cycle.
- R8: With `obl_en`=0 and the block idle, the output mirrors the input: `out_valid`=`in_valid`, the fields are equal, `in_ready`=`out_ready`, and `acc_ready`=0. Blocks passed this way do not enter the stash or advance the access count.
- R9: An entry placed into the slot buffer leaves the stash. Input blocks are stored at the lowest free stash index, and entries left in the stash take part in later write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obl_en | input | 1 | 1 = oblivious path mode, 0 = straight pass-through |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted |
| acc_leaf | input | L | Leaf label of the path just read |
| in_valid | input | 1 | Path block input valid |
| in_ready | output | 1 | Path block input ready |
| in_tag | input | TW | Block tag, 8'hFF = dummy |
| in_leaf | input | L | Block leaf label |
| in_data | input | DW | Block payload |
| out_valid | output | 1 | Write-back block valid |
| out_ready | input | 1 | Write-back block accepted |
| out_tag | output | TW | Write-back tag |
| out_leaf | output | L | Write-back leaf label |
| out_data | output | DW | Write-back payload |
| stash_err | output | 1 | Sticky stash overflow or unplaceable entry |

## Verification
The bench builds the block with its defaults: a 4-level tree below the root, 4 slots per bucket, a 32-entry stash and a write-back period of 5.

- **Overflow.** A single path carries 20 blocks, so two all-real accesses are enough to overrun the 32-entry stash.
- **Root congestion.** A root bucket of only 4 slots saturates as soon as five blocks whose leaves differ in the top bit meet a write-back.
- **Placement paths.** Random leaves with a 1-in-5 real-block rate exercise every shared depth and leftover carry-over across many write-back periods.
- **Directed cases.** Dedicated runs cover the equal-leaf depth, the top-bit depth, back-pressure during write-back and the pass-through mode.

// File: rtl/pes_pkg.sv
// Package: shared state type and path-overlap helper for the eviction scheduler.
// Assumes leaf labels are at most 32 bits wide, MSB choosing the branch below the root.
package pes_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_INTAKE = 2'd1,
        S_PLACE  = 2'd2,
        S_EMIT   = 2'd3
    } pes_state_e;

    // Deepest level shared by two paths, given the XOR of their leaf labels.
    function automatic int shared_depth(input logic [31:0] diff, input int depth);
        int r;
        r = depth;
        for (int b = 0; b < 32; b++) begin
            if (b < depth && diff[b]) r = depth - 1 - b;
        end
        return r;
    endfunction

endpackage

// File: rtl/pes_stash.sv
// Module: on-chip stash holding real blocks between write-backs.
// Inserts at the lowest free index; one insert and one delete may occur per cycle.
// Assumes the caller never inserts while full and never deletes an empty entry.
module pes_stash #(
    parameter int N  = 32,
    parameter int TW = 8,
    parameter int LW = 4,
    parameter int DW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_en,
    input  logic [TW-1:0] ins_tag,
    input  logic [LW-1:0] ins_leaf,
    input  logic [DW-1:0] ins_data,
    output logic          full,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_vld,
    output logic [TW-1:0] rd_tag,
    output logic [LW-1:0] rd_leaf,
    output logic [DW-1:0] rd_data,
    input  logic          del_en,
    input  logic [IW-1:0] del_idx
);

    logic [N-1:0]  vld_q;
    logic [TW-1:0] tag_q  [N];
    logic [LW-1:0] leaf_q [N];
    logic [DW-1:0] data_q [N];
    logic [IW-1:0] free_idx;

    // Priority search for the lowest free entry.
    always_comb begin
        free_idx = '0;
        full     = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx = IW'(i);
                full     = 1'b0;
            end
        end
    end

    // Occupancy bits: set on insert, cleared on delete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (ins_en) vld_q[free_idx] <= 1'b1;
            if (del_en) vld_q[del_idx]  <= 1'b0;
        end
    end

    // Payload storage written on insert.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[free_idx]  <= ins_tag;
            leaf_q[free_idx] <= ins_leaf;
            data_q[free_idx] <= ins_data;
        end
    end

    // Random-access read port used by the placement scan.
    always_comb begin
        rd_vld  = vld_q[rd_idx];
        rd_tag  = tag_q[rd_idx];
        rd_leaf = leaf_q[rd_idx];
        rd_data = data_q[rd_idx];
    end

    // An insert must only be issued when a free entry exists.
    p_ins_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !full);

    // A delete must target an occupied entry.
    p_del_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        del_en |-> vld_q[del_idx]);

endmodule

// File: rtl/pes_slotbuf.sv
// Module: level-indexed slot buffer mapping onto the buckets of one path.
// A put lands in the deepest level not below put_max with a free slot, filling
// slots in order; the read port returns a dummy for unfilled slots.
// Assumes clr and put_en are never asserted together.
module pes_slotbuf #(
    parameter int LV      = 5,
    parameter int Z       = 4,
    parameter int TW      = 8,
    parameter int LW      = 4,
    parameter int DW      = 16,
    parameter logic [TW-1:0] TAG_INV = '1,
    localparam int PB  = LV * Z,
    localparam int SW  = $clog2(PB),
    localparam int LVW = $clog2(LV),
    localparam int FW  = $clog2(Z + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           put_en,
    input  logic [LVW-1:0] put_max,
    input  logic [TW-1:0]  put_tag,
    input  logic [LW-1:0]  put_leaf,
    input  logic [DW-1:0]  put_data,
    output logic           fit,
    input  logic [SW-1:0]  rd_idx,
    output logic [TW-1:0]  rd_tag,
    output logic [LW-1:0]  rd_leaf,
    output logic [DW-1:0]  rd_data
);

    logic [FW-1:0] fill_q [LV];
    logic [PB-1:0] vld_q;
    logic [TW-1:0] tag_q  [PB];
    logic [LW-1:0] leaf_q [PB];
    logic [DW-1:0] data_q [PB];
    logic [LVW-1:0] sel;
    logic [SW-1:0]  waddr;

    // Deepest eligible level that still has room.
    always_comb begin
        fit = 1'b0;
        sel = '0;
        for (int l = 0; l < LV; l++) begin
            if (l <= int'(put_max) && int'(fill_q[l]) < Z) begin
                fit = 1'b1;
                sel = LVW'(l);
            end
        end
        waddr = SW'(int'(sel) * Z + int'(fill_q[sel]));
    end

    // Per-level fill counters and slot occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int l = 0; l < LV; l++) fill_q[l] <= '0;
            vld_q <= '0;
        end else if (put_en) begin
            fill_q[sel]  <= fill_q[sel] + FW'(1);
            vld_q[waddr] <= 1'b1;
        end
    end

    // Slot payload storage.
    always_ff @(posedge clk) begin
        if (put_en) begin
            tag_q[waddr]  <= put_tag;
            leaf_q[waddr] <= put_leaf;
            data_q[waddr] <= put_data;
        end
    end

    // Read port: unfilled slots read back as dummy blocks.
    always_comb begin
        if (vld_q[rd_idx]) begin
            rd_tag  = tag_q[rd_idx];
            rd_leaf = leaf_q[rd_idx];
            rd_data = data_q[rd_idx];
        end else begin
            rd_tag  = TAG_INV;
            rd_leaf = '0;
            rd_data = '0;
        end
    end

    // The controller only places an entry when a level has room.
    p_put_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        put_en |-> fit);

    // A level never holds more than Z blocks.
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        put_en |=> int'(fill_q[$past(sel)]) <= Z);

endmodule

// File: rtl/path_evict_sched.sv
// Module: tree path eviction scheduler (top).
// Takes the leaf of each accessed path, absorbs the path's blocks into the stash,
// and every PERIOD-th access places stash entries into a slot buffer and streams
// the whole path back root first. With obl_en low it is a wire from in to out.
// Assumes obl_en is only acted upon while idle and that the 8'hFF-style all-ones
// tag is never used by a real block.
module path_evict_sched #(
    parameter int L      = 4,
    parameter int Z      = 4,
    parameter int N      = 32,
    parameter int TW     = 8,
    parameter int DW     = 16,
    parameter int PERIOD = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          obl_en,
    input  logic          acc_valid,
    output logic          acc_ready,
    input  logic [L-1:0]  acc_leaf,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [TW-1:0] in_tag,
    input  logic [L-1:0]  in_leaf,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [TW-1:0] out_tag,
    output logic [L-1:0]  out_leaf,
    output logic [DW-1:0] out_data,
    output logic          stash_err
);
    import pes_pkg::*;

    localparam int LV  = L + 1;
    localparam int PB  = LV * Z;
    localparam int SW  = $clog2(PB);
    localparam int IW  = $clog2(N);
    localparam int LVW = $clog2(LV);
    localparam int CW  = $clog2(PERIOD + 1);
    localparam logic [TW-1:0] TAG_INV = '1;

    pes_state_e    state_q;
    logic [L-1:0]  cur_leaf_q;
    logic [SW-1:0] beat_q;
    logic [IW-1:0] scan_q;
    logic [CW-1:0] acc_cnt_q;
    logic          evict_q;
    logic          err_q;

    logic          bypass, beat, beat_last, is_real;
    logic          st_full, st_ins, st_del;
    logic          st_vld;
    logic [TW-1:0] st_tag;
    logic [L-1:0]  st_leaf;
    logic [DW-1:0] st_data;
    logic          sb_fit, sb_put, sb_clr, leftover;
    logic [LVW-1:0] sb_max;
    logic [TW-1:0] sb_tag;
    logic [L-1:0]  sb_leaf;
    logic [DW-1:0] sb_data;

    // Handshake and datapath steering.
    always_comb begin
        bypass    = (state_q == S_IDLE) && !obl_en;
        acc_ready = (state_q == S_IDLE) && obl_en;
        in_ready  = bypass ? out_ready : (state_q == S_INTAKE);
        beat      = in_valid && (state_q == S_INTAKE);
        beat_last = beat_q == SW'(PB - 1);
        is_real   = in_tag != TAG_INV;
        st_ins    = beat && is_real && !st_full;
        sb_clr    = beat && beat_last && evict_q;
        sb_max    = LVW'(shared_depth(32'(st_leaf ^ cur_leaf_q), L));
        sb_put    = (state_q == S_PLACE) && st_vld && sb_fit;
        st_del    = sb_put;
        leftover  = (state_q == S_PLACE) && st_vld && !sb_fit;
    end

    // Output mux: pass-through when disabled, slot buffer during write-back.
    always_comb begin
        if (bypass) begin
            out_valid = in_valid;
            out_tag   = in_tag;
            out_leaf  = in_leaf;
            out_data  = in_data;
        end else begin
            out_valid = state_q == S_EMIT;
            out_tag   = sb_tag;
            out_leaf  = sb_leaf;
            out_data  = sb_data;
        end
    end

    // Access sequencing: intake, optional placement scan, write-back stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cur_leaf_q <= '0;
            beat_q     <= '0;
            scan_q     <= '0;
            acc_cnt_q  <= '0;
            evict_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (acc_valid && acc_ready) begin
                    cur_leaf_q <= acc_leaf;
                    beat_q     <= '0;
                    evict_q    <= acc_cnt_q == CW'(PERIOD - 1);
                    acc_cnt_q  <= (acc_cnt_q == CW'(PERIOD - 1)) ? '0 : acc_cnt_q + CW'(1);
                    state_q    <= S_INTAKE;
                end
                S_INTAKE: if (beat) begin
                    if (beat_last) begin
                        beat_q  <= '0;
                        scan_q  <= '0;
                        state_q <= evict_q ? S_PLACE : S_IDLE;
                    end else begin
                        beat_q <= beat_q + SW'(1);
                    end
                end
                S_PLACE: begin
                    scan_q <= scan_q + IW'(1);
                    if (scan_q == IW'(N - 1)) begin
                        beat_q  <= '0;
                        state_q <= S_EMIT;
                    end
                end
                S_EMIT: if (out_ready) begin
                    if (beat_last) state_q <= S_IDLE;
                    else           beat_q  <= beat_q + SW'(1);
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Sticky error: dropped input block or unplaceable stash entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                err_q <= 1'b0;
        else if ((beat && is_real && st_full) || leftover) err_q <= 1'b1;
    end

    assign stash_err = err_q;

    pes_stash #(.N(N), .TW(TW), .LW(L), .DW(DW)) u_stash (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (st_ins),
        .ins_tag  (in_tag),
        .ins_leaf (in_leaf),
        .ins_data (in_data),
        .full     (st_full),
        .rd_idx   (scan_q),
        .rd_vld   (st_vld),
        .rd_tag   (st_tag),
        .rd_leaf  (st_leaf),
        .rd_data  (st_data),
        .del_en   (st_del),
        .del_idx  (scan_q)
    );

    pes_slotbuf #(.LV(LV), .Z(Z), .TW(TW), .LW(L), .DW(DW), .TAG_INV(TAG_INV)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sb_clr),
        .put_en   (sb_put),
        .put_max  (sb_max),
        .put_tag  (st_tag),
        .put_leaf (st_leaf),
        .put_data (st_data),
        .fit      (sb_fit),
        .rd_idx   (beat_q),
        .rd_tag   (sb_tag),
        .rd_leaf  (sb_leaf),
        .rd_data  (sb_data)
    );

    // Write-back fields hold while the sink stalls.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMIT && !out_ready) |=>
            (out_valid && $stable(out_tag) && $stable(out_leaf) && $stable(out_data)));

    // No input is taken during placement or write-back.
    p_no_intake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PLACE || state_q == S_EMIT) |-> !in_ready);

    // The error flag never clears once raised.
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stash_err |=> stash_err);

    // A write-back is only entered from an access flagged for eviction.
    p_emit_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid && !bypass) |-> evict_q);

endmodule

// File: tb/tb_path_evict_sched.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random accesses against a bench-side model.
module tb_path_evict_sched;

    localparam int NB = 20;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obl_en = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic [3:0]  acc_leaf = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_tag = '0;
    logic [3:0]  in_leaf = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_tag;
    logic [3:0]  out_leaf;
    logic [15:0] out_data;
    logic        stash_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit          m_vld [NS];
    logic [7:0]  m_tag [NS];
    logic [3:0]  m_leaf[NS];
    logic [15:0] m_data[NS];
    int          m_cnt = 0;
    bit          m_err = 1'b0;
    logic [7:0]  e_tag [NB];
    logic [3:0]  e_leaf[NB];
    logic [15:0] e_data[NB];
    logic [7:0]  b_tag [NB];
    logic [3:0]  b_leaf[NB];
    logic [15:0] b_data[NB];

    always #2 clk = ~clk;

    path_evict_sched dut (
        .clk(clk), .rst_n(rst_n), .obl_en(obl_en),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_leaf(acc_leaf),
        .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
        .in_leaf(in_leaf), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_leaf(out_leaf), .out_data(out_data), .stash_err(stash_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int depth_of(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] x;
        x = a ^ b;
        for (int p = 3; p >= 0; p--) if (x[p]) return 3 - p;
        return 4;
    endfunction

    task automatic model_insert(input logic [7:0] t, input logic [3:0] lf, input logic [15:0] d);
        if (t == 8'hFF) return;
        for (int i = 0; i < NS; i++) begin
            if (!m_vld[i]) begin
                m_vld[i] = 1'b1; m_tag[i] = t; m_leaf[i] = lf; m_data[i] = d;
                return;
            end
        end
        m_err = 1'b1;
    endtask

    task automatic model_evict(input logic [3:0] cur);
        int fill [5];
        for (int l = 0; l < 5; l++) fill[l] = 0;
        for (int k = 0; k < NB; k++) begin
            e_tag[k] = 8'hFF; e_leaf[k] = '0; e_data[k] = '0;
        end
        for (int i = 0; i < NS; i++) begin
            if (m_vld[i]) begin
                int d;
                int sel;
                d = depth_of(m_leaf[i], cur);
                sel = -1;
                for (int l = 0; l <= d; l++) if (fill[l] < 4) sel = l;
                if (sel < 0) begin
                    m_err = 1'b1;
                end else begin
                    e_tag[sel*4+fill[sel]]  = m_tag[i];
                    e_leaf[sel*4+fill[sel]] = m_leaf[i];
                    e_data[sel*4+fill[sel]] = m_data[i];
                    fill[sel]++;
                    m_vld[i] = 1'b0;
                end
            end
        end
    endtask

    task automatic fill_dummy();
        for (int k = 0; k < NB; k++) begin
            b_tag[k] = 8'hFF; b_leaf[k] = '0; b_data[k] = '0;
        end
    endtask

    task automatic fill_random();
        for (int k = 0; k < NB; k++) begin
            if ($urandom % 5 == 0) begin
                b_tag[k]  = 8'($urandom % 255);
                b_leaf[k] = 4'($urandom);
                b_data[k] = 16'($urandom);
            end else begin
                b_tag[k] = 8'hFF; b_leaf[k] = 4'($urandom); b_data[k] = 16'($urandom);
            end
        end
    endtask

    task automatic do_access(input logic [3:0] leaf);
        bit evict;
        int got;
        bit stalled;
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", "idle out_valid", out_valid, 0);
        chk(acc_ready == 1'b1, "R1", "acc_ready idle", acc_ready, 1);
        acc_valid = 1'b1; acc_leaf = leaf;
        @(negedge clk);
        acc_valid = 1'b0;
        evict = (m_cnt == 4);
        m_cnt = evict ? 0 : m_cnt + 1;
        for (int k = 0; k < NB; k++) begin
            in_valid = 1'b1; in_tag = b_tag[k]; in_leaf = b_leaf[k]; in_data = b_data[k];
            chk(in_ready == 1'b1, "R2", "in_ready during intake", in_ready, 1);
            model_insert(b_tag[k], b_leaf[k], b_data[k]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2", "in_ready after 20 beats", in_ready, 0);
        if (evict) begin
            model_evict(leaf);
            got = 0;
            stalled = 1'b0;
            while (got < NB && !done) begin
                if (out_valid) begin
                    chk(out_tag == e_tag[got], stalled ? "R7" : "R3 R6", "out_tag", out_tag, e_tag[got]);
                    chk(out_leaf == e_leaf[got], "R6", "out_leaf", out_leaf, e_leaf[got]);
                    chk(out_data == e_data[got], "R9", "out_data", out_data, e_data[got]);
                    chk(in_ready == 1'b0, "R2", "in_ready in write-back", in_ready, 0);
                    out_ready = ($urandom % 4) != 0;
                    stalled = !out_ready;
                    if (out_ready) got++;
                end else begin
                    out_ready = $urandom % 2;
                end
                @(negedge clk);
            end
            out_ready = 1'b0;
            chk(out_valid == 1'b0, "R6", "stream length", out_valid, 0);
        end else begin
            chk(out_valid == 1'b0, "R5", "no write-back", out_valid, 0);
        end
        chk(stash_err == m_err, "R4", "stash_err", stash_err, m_err);
    endtask

    task automatic bypass_phase();
        @(negedge clk);
        obl_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            in_valid = $urandom % 2; in_tag = 8'($urandom); in_leaf = 4'($urandom);
            in_data = 16'($urandom); out_ready = $urandom % 2;
            #1;
            chk(out_valid == in_valid && out_tag == in_tag && out_leaf == in_leaf &&
                out_data == in_data, "R8", "mirror", out_tag, in_tag);
            chk(in_ready == out_ready && acc_ready == 1'b0, "R8", "ready path", in_ready, out_ready);
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0; obl_en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(20150427);
        for (int i = 0; i < NS; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        chk(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
        chk(acc_ready == 1'b1, "R1", "reset acc_ready", acc_ready, 1);
        chk(stash_err == 1'b0, "R1", "reset stash_err", stash_err, 0);

        // Directed R3: equal leaves go to the leaf level, overflow moves up,
        // a one-bit-low difference lands at level 3, a top-bit difference at root.
        fill_dummy();
        for (int k = 0; k < 6; k++) begin
            b_tag[k] = 8'(k + 1); b_leaf[k] = 4'h0; b_data[k] = 16'(16'h100 + k);
        end
        b_tag[9] = 8'h07; b_leaf[9] = 4'h1; b_data[9] = 16'h0707;
        b_tag[13] = 8'h08; b_leaf[13] = 4'h8; b_data[13] = 16'h0808;
        do_access(4'h0);
        fill_dummy();
        for (int a = 0; a < 4; a++) do_access(4'h0);

        // Random accesses with a pass-through interlude.
        for (int n = 0; n < 40; n++) begin
            fill_random();
            do_access(4'($urandom));
            if (n == 17) bypass_phase();
        end

        // Directed R4: all-real paths diverging at the top bit overrun the stash.
        for (int a = 0; a < 6; a++) begin
            for (int k = 0; k < NB; k++) begin
                b_tag[k] = 8'(k + 20 * a); b_leaf[k] = 4'h8; b_data[k] = 16'(a * 100 + k);
            end
            do_access(4'h0);
        end
        chk(stash_err == 1'b1, "R4", "overflow raises stash_err", stash_err, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule